// File: doc/BRIEF.md
# Four-Phase Handshake Word Transfer

This block moves parallel data words from a sending unit to a receiving unit when the two run on clocks with no fixed relation. It has a sender controller and a receiver controller. They are joined by an internal word bus and two control wires. A forward wire announces that the word on the bus is good. A return wire carries the receiver's answer. In sender-led mode the answer means "word taken". In receiver-led mode the answer means "ready for a word".

The sending logic offers a word with a one-cycle request. The sender raises `busy` while the transfer is in progress. The receiving logic sees each delivered word on `rx_word`, together with a one-cycle `rx_valid` pulse. Each side passes the control wire it receives through a two-flop synchronizer before using it.

The sender places the word on the bus a set number of its own cycles before it raises the forward wire. It keeps the word on the bus a set number of cycles after it drops that wire. Both counts are parameters with a default of 2.

Top module: `hs_handshake_xfer`

## Requirements
- R1: While reset is held and right after it, `busy` is 0, `rx_valid` is 0 and `rx_word` is 0.
- R2: With `mode` = 0 (sender-led), each accepted request delivers its word exactly once, in request order, on `rx_word`, marked by `rx_valid`.
- R3: With `mode` = 1 (receiver-led), the receiver first raises its ready wire. Each accepted word is then delivered exactly once and in order. The receiver drops its ready wire in the cycle in which it captures the word.
- R4: A request seen while `busy` is 0 is accepted, and `busy` reads 1 from the next source-clock cycle on. `busy` falls only after the word has been delivered.
- R5: A request made while `busy` is 1 is ignored. No extra word is delivered, and the word held for the transfer in progress does not change.
- R6: The forward wire rises only after the bus has held its current value for at least SETUP_CYC source cycles. So no word arrives sooner than SETUP_CYC source cycles plus two receiver cycles after its request.
- R7: The bus changes only after the forward wire has been low for at least HOLD_CYC source cycles. So `busy` stays high for at least HOLD_CYC source cycles after the word is delivered.
- R8: `rx_valid` is high for exactly one receiver cycle per word. It is raised only when the synchronized forward wire was high in the previous cycle.
- R9: When no request is made, no word is delivered in either mode, even while the receiver is ready and waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Sender-side clock |
| rst_src | input | 1 | Synchronous active-high reset, sender side |
| clk_dst | input | 1 | Receiver-side clock |
| rst_dst | input | 1 | Synchronous active-high reset, receiver side |
| mode | input | 1 | 0 = sender-led handshake, 1 = receiver-led handshake |
| req | input | 1 | One-cycle request to send `req_word` (source clock) |
| req_word | input | DATA_W | Word to send |
| busy | output | 1 | A transfer is in progress; requests are ignored |
| rx_word | output | DATA_W | Last word delivered (receiver clock) |
| rx_valid | output | 1 | One-cycle pulse marking a newly delivered word |

## Verification
The assertions assume that `mode` is fixed while either controller is out of reset. Each `mode` value is taken as a fixed setting, not as a live signal, so there is no synchronizer on it. The stimulus keeps to this: it changes `mode` only while both resets are held. The assertions also assume each reset is held for at least one edge of its own clock, and the bench holds each for several.

Requests are driven half a source cycle away from the edge. The receiver runs on a clock of about 137 MHz, unrelated to the source clock, so the synchronizers see arbitrary phase offsets.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

  localparam logic MODE_SRC_LED = 1'b0;
  localparam logic MODE_DST_LED = 1'b1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_RDY,
    S_SETUP,
    S_WAIT_ACK,
    S_HOLD,
    S_WAIT_REL
  } src_state_t;

  typedef enum logic [1:0] {
    D_IDLE,
    D_WAIT_VALID,
    D_WAIT_DROP
  } dst_state_t;

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_src.sv
`timescale 1ns/1ps
module hs_src
  import hs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic              req,
  input  logic [DATA_W-1:0] word,
  input  logic              line_in,
  output logic              busy,
  output logic [DATA_W-1:0] bus_data,
  output logic              fwd_valid
);
  localparam int MAX_CYC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  src_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] held;
  logic              line_s;
  logic              ack_seen;

  hs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  // Sender-led: answer high means taken; receiver-led: answer low means taken
  assign ack_seen = (mode == MODE_DST_LED) ? !line_s : line_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      held      <= '0;
      busy      <= 1'b0;
      bus_data  <= '0;
      fwd_valid <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req) begin
            held <= word;
            busy <= 1'b1;
            cnt  <= '0;
            if (mode == MODE_DST_LED) begin
              state <= S_WAIT_RDY;
            end else begin
              bus_data <= word;
              state    <= S_SETUP;
            end
          end
        end
        S_WAIT_RDY: begin
          if (line_s) begin
            bus_data <= held;
            cnt      <= '0;
            state    <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (cnt == CNT_W'(SETUP_CYC - 1)) begin
            fwd_valid <= 1'b1;
            state     <= S_WAIT_ACK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT_ACK: begin
          if (ack_seen) begin
            fwd_valid <= 1'b0;
            cnt       <= '0;
            state     <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (cnt == CNT_W'(HOLD_CYC - 1)) begin
            bus_data <= '0;
            if (mode == MODE_DST_LED) begin
              busy  <= 1'b0;
              state <= S_IDLE;
            end else begin
              state <= S_WAIT_REL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT_REL: begin
          if (!line_s) begin
            busy  <= 1'b0;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Timing monitors for the bus spacing checks
  logic [DATA_W-1:0] bus_prev;
  logic [CNT_W-1:0]  bus_age;
  logic [CNT_W-1:0]  low_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_prev <= '0;
      bus_age  <= '0;
      low_age  <= CNT_W'(HOLD_CYC);
    end else begin
      bus_prev <= bus_data;
      if (bus_data != bus_prev)              bus_age <= CNT_W'(1);
      else if (bus_age < CNT_W'(SETUP_CYC))  bus_age <= bus_age + 1'b1;
      if (fwd_valid)                         low_age <= '0;
      else if (low_age < CNT_W'(HOLD_CYC))   low_age <= low_age + 1'b1;
    end
  end

  a_r6_setup_before_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(fwd_valid) |-> (bus_age >= CNT_W'(SETUP_CYC)));

  a_r7_hold_after_valid: assert property (@(posedge clk) disable iff (rst)
    !$stable(bus_data) |-> (!fwd_valid && low_age >= CNT_W'(HOLD_CYC)));

  a_r4_valid_within_busy: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> busy);

  a_r5_word_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(held));

endmodule

// File: rtl/hs_dst.sv
`timescale 1ns/1ps
module hs_dst
  import hs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              fwd_valid,
  output logic              line_out,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  dst_state_t state;
  logic       valid_s;

  hs_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(fwd_valid), .q(valid_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= D_IDLE;
      line_out <= 1'b0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        D_IDLE: begin
          if (mode == MODE_DST_LED) begin
            line_out <= 1'b1;
            state    <= D_WAIT_VALID;
          end else if (valid_s) begin
            rx_word  <= bus_data;
            rx_valid <= 1'b1;
            line_out <= 1'b1;
            state    <= D_WAIT_DROP;
          end
        end
        D_WAIT_VALID: begin
          if (valid_s) begin
            rx_word  <= bus_data;
            rx_valid <= 1'b1;
            line_out <= 1'b0;
            state    <= D_WAIT_DROP;
          end
        end
        D_WAIT_DROP: begin
          if (!valid_s) begin
            line_out <= 1'b0;
            state    <= D_IDLE;
          end
        end
        default: state <= D_IDLE;
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r8_pulse_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(valid_s));

  a_r3_ready_dropped_on_capture: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && mode == MODE_DST_LED) |-> !line_out);

endmodule

// File: rtl/hs_handshake_xfer.sv
`timescale 1ns/1ps
module hs_handshake_xfer #(
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_src,
  input  logic              rst_src,
  input  logic              clk_dst,
  input  logic              rst_dst,
  input  logic              mode,
  input  logic              req,
  input  logic [DATA_W-1:0] req_word,
  output logic              busy,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [DATA_W-1:0] link_bus;
  logic              link_fwd;
  logic              link_ret;

  hs_src #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .SYNC_STG(SYNC_STG)
  ) u_src (
    .clk(clk_src), .rst(rst_src), .mode(mode), .req(req), .word(req_word),
    .line_in(link_ret), .busy(busy), .bus_data(link_bus), .fwd_valid(link_fwd)
  );

  hs_dst #(
    .DATA_W(DATA_W), .SYNC_STG(SYNC_STG)
  ) u_dst (
    .clk(clk_dst), .rst(rst_dst), .mode(mode), .bus_data(link_bus),
    .fwd_valid(link_fwd), .line_out(link_ret), .rx_word(rx_word), .rx_valid(rx_valid)
  );
endmodule

// File: tb/test_hs_handshake_xfer.sv
`timescale 1ns/1ps
module test_hs_handshake_xfer;
  localparam int DW = 8;
  localparam int SETUP = 2;
  localparam int HOLD = 2;
  localparam real TS = 10.0;
  localparam real TD = 7.3;

  logic clk_src = 0, clk_dst = 0, rst_src = 1, rst_dst = 1;
  logic mode = 0, req = 0;
  logic [DW-1:0] req_word = '0;
  logic busy, rx_valid;
  logic [DW-1:0] rx_word;

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q [0:63];
  int exp_wr = 0, rx_cnt = 0;
  real t_req = 0.0, t_rx = 0.0;
  string tag = "R2";

  always #(TS/2) clk_src = ~clk_src;
  always #(TD/2) clk_dst = ~clk_dst;

  hs_handshake_xfer #(.DATA_W(DW), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) i_hs_handshake_xfer (
    .clk_src(clk_src), .rst_src(rst_src), .clk_dst(clk_dst), .rst_dst(rst_dst),
    .mode(mode), .req(req), .req_word(req_word), .busy(busy),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req_id, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req_id, act, exp, $time);
    end
  endtask

  // Scoreboard: order, uniqueness and pulse width (R2, R3, R8)
  logic rx_prev = 0;
  always @(negedge clk_dst) begin
    if (!rst_dst) begin
      if (rx_valid && rx_prev) check(0, "R8", 1, 0);
      if (rx_valid) begin
        t_rx = $realtime;
        if (rx_cnt >= exp_wr) check(0, tag, rx_cnt + 1, exp_wr);
        else check(rx_word == exp_q[rx_cnt], tag, rx_word, exp_q[rx_cnt]);
        rx_cnt++;
      end
    end
    rx_prev = rx_valid;
  end

  task automatic do_reset(input logic m);
    rst_src = 1; rst_dst = 1;
    repeat (4) @(negedge clk_src);
    mode = m;
    tag = m ? "R3" : "R2";
    repeat (4) @(negedge clk_dst);
    @(negedge clk_src); rst_src = 0;
    @(negedge clk_dst); rst_dst = 0;
    @(negedge clk_src);
  endtask

  task automatic send(input logic [DW-1:0] w);
    int guard = 0;
    @(negedge clk_src);
    while (busy && guard < 1000) begin @(negedge clk_src); guard++; end
    req = 1; req_word = w;
    exp_q[exp_wr] = w; exp_wr++;
    t_req = $realtime;
    @(negedge clk_src);
    req = 0;
    check(busy == 1'b1, "R4", busy, 1);
  endtask

  task automatic drain(input string req_id);
    int guard = 0;
    while ((rx_cnt != exp_wr || busy) && guard < 2000) begin @(negedge clk_src); guard++; end
    check(rx_cnt == exp_wr, req_id, rx_cnt, exp_wr);
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    check(busy == 1'b0, "R1", busy, 0);
    check(rx_valid == 1'b0, "R1", rx_valid, 0);
    check(rx_word == '0, "R1", rx_word, 0);
  endtask

  task automatic t_quiet(input logic m);
    int base;
    do_reset(m);
    base = rx_cnt;
    repeat (60) @(negedge clk_src);
    check(rx_cnt == base, "R9", rx_cnt, base);
    check(busy == 1'b0, "R9", busy, 0);
  endtask

  task automatic t_stream(input logic m);
    do_reset(m);
    send(8'hA5); send(8'h00); send(8'hFF); send(8'h3C);
    send(8'h01); send(8'h80); send(8'h5A);
    drain(m ? "R3" : "R2");
  endtask

  task automatic t_busy_timing(input logic m);
    int guard = 0;
    real lat;
    do_reset(m);
    send(8'hC3);
    while (busy && guard < 1000) begin
      @(negedge clk_src); guard++;
    end
    check(rx_cnt == exp_wr, "R4", rx_cnt, exp_wr);
    lat = t_rx - t_req;
    check(lat >= SETUP * TS + 2.0 * TD, "R6", int'(lat), int'(SETUP * TS + 2.0 * TD));
    lat = $realtime - t_rx;
    check(lat >= HOLD * TS, "R7", int'(lat), int'(HOLD * TS));
  endtask

  task automatic t_ignore(input logic m);
    do_reset(m);
    send(8'h11);
    req = 1; req_word = 8'hEE;
    repeat (3) @(negedge clk_src);
    req = 0;
    drain("R5");
    repeat (80) @(negedge clk_src);
    check(rx_cnt == exp_wr, "R5", rx_cnt, exp_wr);
    check(rx_word == 8'h11, "R5", rx_word, 8'h11);
  endtask

  initial begin
    t_reset_state();
    t_quiet(1'b0);
    t_quiet(1'b1);
    t_stream(1'b0);
    t_stream(1'b1);
    t_busy_timing(1'b0);
    t_busy_timing(1'b1);
    t_ignore(1'b0);
    t_ignore(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", rx_cnt, exp_wr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule